// File: doc/BRIEF.md
# Dual-Side Mailbox Register Bank

A byte-wide register bank shared by a host processor and a management controller. Each side has its own synchronous write port and an always-valid read port into a common 32-byte window. The window holds fifteen message bytes (command at 0x00, sequence number at 0x01, eleven payload bytes at 0x02..0x0C, response at 0x0D, one spare byte at 0x0E). It also holds an event flag byte, two status bytes, one control register for each side and four interrupt-enable bytes.

Each side rings the other through its own control register. Writing the send bit sets a sticky pending bit in the other side's control register, and that side clears it by writing one to it. A nonzero write to the event flag raises an attention bit that the host acknowledges by writing one to it. Each side has one interrupt output. It is driven by its unmasked pending doorbell and by any status bit that its enable bytes let through.

Top module: `mbox_regbank`

## Requirements
- R1: Offsets 0x00..0x0E are message bytes that either side can write and both sides read. Offset 0x0F is the event flag: the management side writes it, both sides read it, and a host write to it has no effect.
- R2: When both sides write the same message byte in the same cycle, the management-side value is stored.
- R3: After reset every register reads 0x00 on both ports and both interrupt outputs are low.
- R4: A host write to 0x13 with bit 0 set sets bit 7 of 0x12. The management interrupt is high while 0x12 bit 7 is 1 and 0x12 bit 1 (mask) is 0.
- R5: A management write to 0x12 with bit 0 set sets bit 7 of 0x13. The host interrupt is high while 0x13 bit 7 is 1 and 0x13 bit 1 is 0.
- R6: Bit 7 of a control register is cleared only when its own side writes a 1 to it. Writing 0 leaves it set. If the other side's send arrives in the same cycle as the clear, the bit stays set.
- R7: In both control registers, bit 0 (send) and bits 6..2 always read 0. Bit 1 is stored from the owning side's write. A write to the other side's control register has no effect.
- R8: A management write of a nonzero value to 0x0F sets bit 7 of 0x11. A write of 0x00 does not set it.
- R9: A management write to 0x10 or 0x11 sets the written 1-bits, and a host write clears the written 1-bits. If the same bit is set and cleared in one cycle, it ends set.
- R10: The host interrupt is also high when any bit of 0x10 AND 0x16, or of 0x11 AND 0x17, is 1. The management interrupt is also high when any bit of 0x10 AND 0x14, or of 0x11 AND 0x15, is 1.
- R11: Bytes 0x14/0x15 are written only by the management side and bytes 0x16/0x17 only by the host. Both sides can read all four.
- R12: Offsets 0x18..0x1F read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| h_we_i | input | 1 | Host write strobe |
| h_addr_i | input | 5 | Host byte offset |
| h_wdata_i | input | 8 | Host write data |
| h_rdata_o | output | 8 | Host read data at h_addr_i |
| m_we_i | input | 1 | Management write strobe |
| m_addr_i | input | 5 | Management byte offset |
| m_wdata_i | input | 8 | Management write data |
| m_rdata_o | output | 8 | Management read data at m_addr_i |
| host_irq_o | output | 1 | Interrupt toward the host |
| mgmt_irq_o | output | 1 | Interrupt toward the management side |

## Verification
Every register is updated on the clock edge that samples the write strobe. Both read ports and both interrupt outputs are decoded from register state without further flops, so each result is due exactly one edge after its stimulus. The bench drives on the falling edge. It checks read data and interrupt levels at the next falling edge, after the capturing rising edge, and repoints the read address with a small delay while the clock is still low. The control-register sweep covers all 256 write values, and the status-gating sweep covers every bit position against several enable patterns, with expected values taken from bit arithmetic.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DW = 8;
  localparam int AW = 5;
  localparam int MSG_BYTES = 15;

  localparam logic [AW-1:0] A_FLAG   = 5'h0F;
  localparam logic [AW-1:0] A_STAT0  = 5'h10;
  localparam logic [AW-1:0] A_STAT1  = 5'h11;
  localparam logic [AW-1:0] A_CTRL_M = 5'h12;
  localparam logic [AW-1:0] A_CTRL_H = 5'h13;
  localparam logic [AW-1:0] A_MEN0   = 5'h14;
  localparam logic [AW-1:0] A_MEN1   = 5'h15;
  localparam logic [AW-1:0] A_HEN0   = 5'h16;
  localparam logic [AW-1:0] A_HEN1   = 5'h17;

  localparam int B_PEND = 7;
  localparam int B_MASK = 1;
  localparam int B_SEND = 0;
  localparam int B_ATTN = 7;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } wr_t;
endpackage

// File: rtl/mbox_msg_bank.sv
module mbox_msg_bank
  import mbox_pkg::*;
#(
  parameter int N = MSG_BYTES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  wr_t                h_wr_i,
  input  wr_t                m_wr_i,
  output logic [N-1:0][DW-1:0] msg_o
);
  for (genvar i = 0; i < N; i++) begin : g_byte
    logic h_hit, m_hit;
    assign h_hit = h_wr_i.we && (h_wr_i.addr == AW'(i));
    assign m_hit = m_wr_i.we && (m_wr_i.addr == AW'(i));
    // management side wins a same-byte collision
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    msg_o[i] <= '0;
      else if (m_hit) msg_o[i] <= m_wr_i.wdata;
      else if (h_hit) msg_o[i] <= h_wr_i.wdata;
    end
  end
endmodule

// File: rtl/mbox_ctrl_pair.sv
module mbox_ctrl_pair
  import mbox_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  wr_t           h_wr_i,
  input  wr_t           m_wr_i,
  output logic [DW-1:0] ctrl_m_o,
  output logic [DW-1:0] ctrl_h_o
);
  logic m_pend_q, m_mask_q, h_pend_q, h_mask_q;
  logic m_pend_d, h_pend_d;
  logic h_hit, m_hit, h_send, m_send, h_ack, m_ack;

  assign h_hit  = h_wr_i.we && (h_wr_i.addr == A_CTRL_H);
  assign m_hit  = m_wr_i.we && (m_wr_i.addr == A_CTRL_M);
  assign h_send = h_hit && h_wr_i.wdata[B_SEND];
  assign m_send = m_hit && m_wr_i.wdata[B_SEND];
  assign h_ack  = h_hit && h_wr_i.wdata[B_PEND];
  assign m_ack  = m_hit && m_wr_i.wdata[B_PEND];

  // set beats clear when both land in one cycle
  always_comb begin
    m_pend_d = (m_pend_q && !m_ack) || h_send;
    h_pend_d = (h_pend_q && !h_ack) || m_send;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pend_q <= 1'b0;
      m_mask_q <= 1'b0;
      h_pend_q <= 1'b0;
      h_mask_q <= 1'b0;
    end else begin
      m_pend_q <= m_pend_d;
      h_pend_q <= h_pend_d;
      if (m_hit) m_mask_q <= m_wr_i.wdata[B_MASK];
      if (h_hit) h_mask_q <= h_wr_i.wdata[B_MASK];
    end
  end

  always_comb begin
    ctrl_m_o = '0;
    ctrl_m_o[B_PEND] = m_pend_q;
    ctrl_m_o[B_MASK] = m_mask_q;
    ctrl_h_o = '0;
    ctrl_h_o[B_PEND] = h_pend_q;
    ctrl_h_o[B_MASK] = h_mask_q;
  end
endmodule

// File: rtl/mbox_status.sv
module mbox_status
  import mbox_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  wr_t           h_wr_i,
  input  wr_t           m_wr_i,
  output logic [DW-1:0] flag_o,
  output logic [DW-1:0] stat0_o,
  output logic [DW-1:0] stat1_o
);
  logic          flag_wr;
  logic [DW-1:0] set0, set1, clr0, clr1;

  assign flag_wr = m_wr_i.we && (m_wr_i.addr == A_FLAG);

  always_comb begin
    set0 = (m_wr_i.we && m_wr_i.addr == A_STAT0) ? m_wr_i.wdata : '0;
    set1 = (m_wr_i.we && m_wr_i.addr == A_STAT1) ? m_wr_i.wdata : '0;
    if (flag_wr && (m_wr_i.wdata != '0)) set1[B_ATTN] = 1'b1;
    clr0 = (h_wr_i.we && h_wr_i.addr == A_STAT0) ? h_wr_i.wdata : '0;
    clr1 = (h_wr_i.we && h_wr_i.addr == A_STAT1) ? h_wr_i.wdata : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o  <= '0;
      stat0_o <= '0;
      stat1_o <= '0;
    end else begin
      if (flag_wr) flag_o <= m_wr_i.wdata;
      stat0_o <= (stat0_o & ~clr0) | set0;
      stat1_o <= (stat1_o & ~clr1) | set1;
    end
  end
endmodule

// File: rtl/mbox_irq_gate.sv
module mbox_irq_gate
  import mbox_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  wr_t           h_wr_i,
  input  wr_t           m_wr_i,
  input  logic [DW-1:0] stat0_i,
  input  logic [DW-1:0] stat1_i,
  input  logic [DW-1:0] ctrl_m_i,
  input  logic [DW-1:0] ctrl_h_i,
  output logic [DW-1:0] men0_o,
  output logic [DW-1:0] men1_o,
  output logic [DW-1:0] hen0_o,
  output logic [DW-1:0] hen1_o,
  output logic          host_irq_o,
  output logic          mgmt_irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      men0_o <= '0;
      men1_o <= '0;
      hen0_o <= '0;
      hen1_o <= '0;
    end else begin
      if (m_wr_i.we && m_wr_i.addr == A_MEN0) men0_o <= m_wr_i.wdata;
      if (m_wr_i.we && m_wr_i.addr == A_MEN1) men1_o <= m_wr_i.wdata;
      if (h_wr_i.we && h_wr_i.addr == A_HEN0) hen0_o <= h_wr_i.wdata;
      if (h_wr_i.we && h_wr_i.addr == A_HEN1) hen1_o <= h_wr_i.wdata;
    end
  end

  assign host_irq_o = (ctrl_h_i[B_PEND] && !ctrl_h_i[B_MASK])
                    || |(stat0_i & hen0_o) || |(stat1_i & hen1_o);
  assign mgmt_irq_o = (ctrl_m_i[B_PEND] && !ctrl_m_i[B_MASK])
                    || |(stat0_i & men0_o) || |(stat1_i & men1_o);
endmodule

// File: rtl/mbox_regbank.sv
module mbox_regbank
  import mbox_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h_we_i,
  input  logic [AW-1:0] h_addr_i,
  input  logic [DW-1:0] h_wdata_i,
  output logic [DW-1:0] h_rdata_o,
  input  logic          m_we_i,
  input  logic [AW-1:0] m_addr_i,
  input  logic [DW-1:0] m_wdata_i,
  output logic [DW-1:0] m_rdata_o,
  output logic          host_irq_o,
  output logic          mgmt_irq_o
);
  wr_t h_wr, m_wr;
  logic [MSG_BYTES-1:0][DW-1:0] msg_q;
  logic [DW-1:0] flag_q, stat0_q, stat1_q, ctrl_m_q, ctrl_h_q;
  logic [DW-1:0] men0_q, men1_q, hen0_q, hen1_q;

  assign h_wr = '{we: h_we_i, addr: h_addr_i, wdata: h_wdata_i};
  assign m_wr = '{we: m_we_i, addr: m_addr_i, wdata: m_wdata_i};

  mbox_msg_bank #(.N(MSG_BYTES)) u_msg (
    .clk_i(clk_i), .rst_ni(rst_ni), .h_wr_i(h_wr), .m_wr_i(m_wr), .msg_o(msg_q)
  );

  mbox_ctrl_pair u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .h_wr_i(h_wr), .m_wr_i(m_wr),
    .ctrl_m_o(ctrl_m_q), .ctrl_h_o(ctrl_h_q)
  );

  mbox_status u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .h_wr_i(h_wr), .m_wr_i(m_wr),
    .flag_o(flag_q), .stat0_o(stat0_q), .stat1_o(stat1_q)
  );

  mbox_irq_gate u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .h_wr_i(h_wr), .m_wr_i(m_wr),
    .stat0_i(stat0_q), .stat1_i(stat1_q), .ctrl_m_i(ctrl_m_q), .ctrl_h_i(ctrl_h_q),
    .men0_o(men0_q), .men1_o(men1_q), .hen0_o(hen0_q), .hen1_o(hen1_q),
    .host_irq_o(host_irq_o), .mgmt_irq_o(mgmt_irq_o)
  );

  function automatic logic [DW-1:0] rd_mux(input logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = '0;
    if (int'(a) < MSG_BYTES) r = msg_q[a[3:0]];
    else begin
      case (a)
        A_FLAG:   r = flag_q;
        A_STAT0:  r = stat0_q;
        A_STAT1:  r = stat1_q;
        A_CTRL_M: r = ctrl_m_q;
        A_CTRL_H: r = ctrl_h_q;
        A_MEN0:   r = men0_q;
        A_MEN1:   r = men1_q;
        A_HEN0:   r = hen0_q;
        A_HEN1:   r = hen1_q;
        default:  r = '0;
      endcase
    end
    return r;
  endfunction

  assign h_rdata_o = rd_mux(h_addr_i);
  assign m_rdata_o = rd_mux(m_addr_i);
endmodule

// File: rtl/mbox_regbank_chk.sv
module mbox_regbank_chk
  import mbox_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          h_we_i,
  input logic [AW-1:0] h_addr_i,
  input logic [DW-1:0] h_wdata_i,
  input logic [DW-1:0] h_rdata_o,
  input logic          m_we_i,
  input logic [AW-1:0] m_addr_i,
  input logic [DW-1:0] m_wdata_i,
  input logic          host_irq_o,
  input logic [DW-1:0] ctrl_m_q,
  input logic [DW-1:0] ctrl_h_q,
  input logic [DW-1:0] stat1_q
);
  // R4
  h2m_doorbell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_we_i && h_addr_i == A_CTRL_H && h_wdata_i[B_SEND]) |=> ctrl_m_q[B_PEND]);

  // R5
  m2h_doorbell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_we_i && m_addr_i == A_CTRL_M && m_wdata_i[B_SEND]) |=> ctrl_h_q[B_PEND]);

  // R6
  host_ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_we_i && h_addr_i == A_CTRL_H && h_wdata_i[B_PEND]
     && !(m_we_i && m_addr_i == A_CTRL_M && m_wdata_i[B_SEND])) |=> !ctrl_h_q[B_PEND]);

  // R7
  send_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_addr_i == A_CTRL_H || h_addr_i == A_CTRL_M) |-> (h_rdata_o[B_SEND] == 1'b0));

  // R8
  flag_attn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_we_i && m_addr_i == A_FLAG && m_wdata_i != '0) |=> stat1_q[B_ATTN]);

  // R10
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!h_we_i && !m_we_i) |=> $stable(host_irq_o));

  // R12
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_addr_i >= 5'h18) |-> (h_rdata_o == '0));
endmodule

bind mbox_regbank mbox_regbank_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .h_we_i(h_we_i), .h_addr_i(h_addr_i), .h_wdata_i(h_wdata_i), .h_rdata_o(h_rdata_o),
  .m_we_i(m_we_i), .m_addr_i(m_addr_i), .m_wdata_i(m_wdata_i),
  .host_irq_o(host_irq_o),
  .ctrl_m_q(ctrl_m_q), .ctrl_h_q(ctrl_h_q), .stat1_q(stat1_q)
);

// File: tb/tb_mbox_regbank.sv
module tb_mbox_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_we = 1'b0, m_we = 1'b0;
  logic [4:0] h_addr = '0, m_addr = '0;
  logic [7:0] h_wdata = '0, m_wdata = '0;
  logic [7:0] h_rdata, m_rdata;
  logic host_irq, mgmt_irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mbox_regbank dut (
    .clk_i(clk), .rst_ni(rst_n),
    .h_we_i(h_we), .h_addr_i(h_addr), .h_wdata_i(h_wdata), .h_rdata_o(h_rdata),
    .m_we_i(m_we), .m_addr_i(m_addr), .m_wdata_i(m_wdata), .m_rdata_o(m_rdata),
    .host_irq_o(host_irq), .mgmt_irq_o(mgmt_irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // both writes land on the same rising edge; returns at the following falling edge
  task automatic wr2(input logic hw, input logic [4:0] ha, input logic [7:0] hd,
                     input logic mw, input logic [4:0] ma, input logic [7:0] md);
    @(negedge clk);
    h_we = hw; h_addr = ha; h_wdata = hd;
    m_we = mw; m_addr = ma; m_wdata = md;
    @(negedge clk);
    h_we = 1'b0; m_we = 1'b0;
  endtask

  task automatic hw(input logic [4:0] a, input logic [7:0] d);
    wr2(1'b1, a, d, 1'b0, 5'h0, 8'h0);
  endtask

  task automatic mw(input logic [4:0] a, input logic [7:0] d);
    wr2(1'b0, 5'h0, 8'h0, 1'b1, a, d);
  endtask

  task automatic rh(input logic [4:0] a, output logic [7:0] d);
    h_addr = a; #0.5; d = h_rdata;
  endtask

  task automatic rm(input logic [4:0] a, output logic [7:0] d);
    m_addr = a; #0.5; d = m_rdata;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    for (int a = 0; a < 32; a++) begin
      rh(5'(a), v); chk("R3 host reset read", v, 8'h00);
      rm(5'(a), v); chk("R3 mgmt reset read", v, 8'h00);
    end
    chk("R3 host irq", {7'b0, host_irq}, 8'h00);
    chk("R3 mgmt irq", {7'b0, mgmt_irq}, 8'h00);

    // R1 message bytes both directions
    for (int i = 0; i < 15; i++) begin
      hw(5'(i), 8'((i * 37 + 5) & 255));
      rm(5'(i), v); chk("R1 host->mgmt byte", v, 8'((i * 37 + 5) & 255));
      mw(5'(i), 8'(~((i * 37 + 5) & 255)));
      rh(5'(i), v); chk("R1 mgmt->host byte", v, 8'(~((i * 37 + 5) & 255)));
    end
    mw(5'h0F, 8'h00);
    rh(5'h11, v); chk("R8 zero flag no attn", v, 8'h00);
    hw(5'h0F, 8'h5A);
    rh(5'h0F, v); chk("R1 host flag write ignored", v, 8'h00);

    // R2 collision
    wr2(1'b1, 5'h05, 8'hAA, 1'b1, 5'h05, 8'h55);
    rh(5'h05, v); chk("R2 mgmt wins", v, 8'h55);
    wr2(1'b1, 5'h06, 8'hC3, 1'b1, 5'h07, 8'h3C);
    rh(5'h06, v); chk("R2 distinct host", v, 8'hC3);
    rh(5'h07, v); chk("R2 distinct mgmt", v, 8'h3C);

    // R4 R7 sweep of host control writes
    for (int x = 0; x < 256; x++) begin
      hw(5'h13, 8'(x));
      rh(5'h13, v); chk("R7 host ctrl readback", v, 8'(x & 2));
      rm(5'h12, v); chk("R4 mgmt pending", v, (x & 1) ? 8'h80 : 8'h00);
      chk("R4 mgmt irq", {7'b0, mgmt_irq}, 8'(x & 1));
      chk("R5 host irq quiet", {7'b0, host_irq}, 8'h00);
      mw(5'h12, 8'h80);
      rm(5'h12, v); chk("R6 mgmt ack clears", v, 8'h00);
      hw(5'h13, 8'h00);
    end

    // R4 mask
    mw(5'h12, 8'h02);
    hw(5'h13, 8'h01);
    rm(5'h12, v); chk("R4 masked pending", v, 8'h82);
    chk("R4 masked irq low", {7'b0, mgmt_irq}, 8'h00);
    mw(5'h12, 8'h00);
    chk("R6 zero write keeps pending", {7'b0, mgmt_irq}, 8'h01);
    mw(5'h12, 8'h80);
    chk("R6 ack drops irq", {7'b0, mgmt_irq}, 8'h00);

    // R5 R7 mgmt doorbell, cross-side writes ignored
    hw(5'h12, 8'h83);
    rm(5'h12, v); chk("R7 host write to mgmt ctrl ignored", v, 8'h00);
    mw(5'h13, 8'h03);
    rh(5'h13, v); chk("R7 mgmt write to host ctrl ignored", v, 8'h00);
    mw(5'h12, 8'h01);
    rh(5'h13, v); chk("R5 host pending", v, 8'h80);
    chk("R5 host irq", {7'b0, host_irq}, 8'h01);
    hw(5'h13, 8'h02);
    chk("R5 host mask gates irq", {7'b0, host_irq}, 8'h00);
    rh(5'h13, v); chk("R6 pending survives zero", v, 8'h82);
    wr2(1'b1, 5'h13, 8'h80, 1'b1, 5'h12, 8'h01);
    rh(5'h13, v); chk("R6 set beats clear", v, 8'h80);
    hw(5'h13, 8'h80);
    rh(5'h13, v); chk("R6 host ack clears", v, 8'h00);
    chk("R6 host irq low", {7'b0, host_irq}, 8'h00);

    // R8 flag attention
    hw(5'h17, 8'h80);
    mw(5'h0F, 8'h01);
    rh(5'h0F, v); chk("R1 flag readback", v, 8'h01);
    rh(5'h11, v); chk("R8 attention set", v, 8'h80);
    chk("R8 host irq via attention", {7'b0, host_irq}, 8'h01);
    hw(5'h11, 8'h80);
    rh(5'h11, v); chk("R9 host clears attention", v, 8'h00);
    chk("R8 host irq drops", {7'b0, host_irq}, 8'h00);
    hw(5'h17, 8'h00);

    // R9 set/clear, set wins
    mw(5'h10, 8'h0F);
    mw(5'h10, 8'hF0);
    rh(5'h10, v); chk("R9 status OR", v, 8'hFF);
    hw(5'h10, 8'h3C);
    rh(5'h10, v); chk("R9 host W1C", v, 8'hC3);
    wr2(1'b1, 5'h10, 8'hFF, 1'b1, 5'h10, 8'h01);
    rh(5'h10, v); chk("R9 set beats clear", v, 8'h01);
    hw(5'h10, 8'hFF);

    // R10 gating sweep over each status bit and enable pattern
    for (int r = 0; r < 2; r++) begin
      for (int b = 0; b < 8; b++) begin
        for (int p = 0; p < 3; p++) begin
          e = (p == 0) ? 8'hFF : (p == 1) ? 8'(~(1 << b)) : 8'(1 << b);
          hw(5'(8'h16 + r), e);
          mw(5'(8'h14 + r), 8'(~e));
          mw(5'(8'h10 + r), 8'(1 << b));
          chk("R10 host gate", {7'b0, host_irq}, 8'((e >> b) & 1));
          chk("R10 mgmt gate", {7'b0, mgmt_irq}, 8'(((~e) >> b) & 1));
          hw(5'(8'h10 + r), 8'hFF);
          chk("R10 host clear", {7'b0, host_irq}, 8'h00);
        end
        hw(5'(8'h16 + r), 8'h00);
        mw(5'(8'h14 + r), 8'h00);
      end
    end

    // R11 enable ownership
    hw(5'h14, 8'hFF); hw(5'h15, 8'hFF);
    mw(5'h16, 8'hFF); mw(5'h17, 8'hFF);
    rm(5'h14, v); chk("R11 host cannot write 0x14", v, 8'h00);
    rm(5'h15, v); chk("R11 host cannot write 0x15", v, 8'h00);
    rh(5'h16, v); chk("R11 mgmt cannot write 0x16", v, 8'h00);
    rh(5'h17, v); chk("R11 mgmt cannot write 0x17", v, 8'h00);
    mw(5'h15, 8'h21); hw(5'h16, 8'h12);
    rh(5'h15, v); chk("R11 host sees mgmt enable", v, 8'h21);
    rm(5'h16, v); chk("R11 mgmt sees host enable", v, 8'h12);

    // R12 reserved
    for (int a = 24; a < 32; a++) begin
      wr2(1'b1, 5'(a), 8'hFF, 1'b1, 5'(a), 8'hFF);
      rh(5'(a), v); chk("R12 reserved host", v, 8'h00);
      rm(5'(a), v); chk("R12 reserved mgmt", v, 8'h00);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule